// File: doc/BRIEF.md
# Configurable Watchdog Supervisor Timer

This block supervises a processor that must prove it is alive by moving a kick line. A cycle counter measures the time since the last accepted kick. When the count runs out, the block pulls its active-low alarm output low so that it can reset the processor or raise an alert. An active-high disable input stops all supervision. Every duration is a clock-cycle count parameter, so the block fits any clock rate.

A mode parameter selects one of two kick and alarm policies. In the rising-edge policy, only low-to-high kick transitions count. A kick that arrives during an alarm ends the alarm early, but only after a guaranteed minimum alarm width. In the dual-edge policy, both kick transitions count. The alarm then always runs a fixed number of cycles, and kicks that arrive during it are ignored. The kick and disable inputs each pass through a two-flop synchronizer and then a persistence filter. Edges are detected only on the filtered level.

Top module: `wdog_sup`

## Requirements
- R1: After reset the output is high and the counter starts at zero. With no kick and disable low, the output falls exactly TIMEOUT_CYC clock edges after reset is released.
- R2: An accepted kick clears the counter. A kick level change presented before edge a is acted on at edge a+FILT_CYC+2. With no further kick, the output then falls at edge a+FILT_CYC+2+TIMEOUT_CYC. Every change of the output level also restarts the count from zero.
- R3: With MODE = WD_RISE_EARLY (value 0), only filtered low-to-high kick transitions are accepted. Falling transitions have no effect on the timing.
- R4: With MODE = WD_RISE_EARLY and no kicks, the output stays low for TIMEOUT_CYC cycles, then high for TIMEOUT_CYC cycles, and repeats.
- R5: With MODE = WD_RISE_EARLY, an accepted kick during an alarm releases the output. The release comes on the first edge at which the output has been low for at least MIN_LOW_CYC cycles, and never sooner.
- R6: With MODE = WD_DUAL_FIXED (value 1), both filtered kick transitions, rising and falling, are accepted while the output is high.
- R7: With MODE = WD_DUAL_FIXED, an alarm lasts exactly ALARM_CYC cycles. Kicks during an alarm are ignored. With no kicks, the output alternates ALARM_CYC cycles low and TIMEOUT_CYC cycles high.
- R8: While the filtered disable is high and the output is high, the output stays high and the counter is held at zero. After disable falls (presented before edge b), the output falls at edge b+FILT_CYC+1+TIMEOUT_CYC.
- R9: If disable becomes active during an alarm, the output is released once it has been low for at least MIN_LOW_CYC cycles. This holds in both modes.
- R10: A kick or disable pulse shorter than FILT_CYC clock cycles is discarded. A pulse held for FILT_CYC cycles or more is accepted.
- R11: While the output is high, a kick and an expiring count on the same edge resolve in favour of the kick. The output stays high and the count restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | Asynchronous kick line from the supervised processor |
| dis_i | input | 1 | Asynchronous active-high disable |
| wdo_n_o | output | 1 | Active-low watchdog alarm, registered |

## Verification
The output is the only thing the outside world sees, so a corrupted counter or phase flag can only show up as an output edge at the wrong cycle. The bench predicts each fall and rise to the exact edge from the kick latency and the cycle parameters, and checks the cycles on both sides. An off-by-one in the counter, the filter or the edge detector therefore fails within one timeout period. A lost pending-release flag shows up as an alarm that runs to its full length instead of ending after the minimum width. A wrongly accepted edge shows up as an alarm that comes later than predicted.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        WD_RISE_EARLY = 1'b0,
        WD_DUAL_FIXED = 1'b1
    } wdog_mode_e;

    function automatic int unsigned wd_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[1];
endmodule

// File: rtl/wdog_filt.sv
module wdog_filt #(
    parameter int unsigned FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned FW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
    localparam logic [FW-1:0] RUN_LAST = FW'(FILT_CYC - 1);

    typedef struct packed {
        logic          lvl;
        logic [FW-1:0] run;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din != st_q.lvl) begin
            if (st_q.run == RUN_LAST) begin
                st_d.lvl = din;
                st_d.run = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.lvl;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 200,
    parameter int unsigned ALARM_CYC   = 120,
    parameter int unsigned MIN_LOW_CYC = 10,
    parameter wdog_mode_e  MODE        = WD_RISE_EARLY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_f,
    input  logic dis_f,
    output logic wdo_n
);
    localparam int unsigned LOW_LEN = (MODE == WD_RISE_EARLY) ? TIMEOUT_CYC : ALARM_CYC;
    localparam int unsigned CW      = $clog2(wd_max(TIMEOUT_CYC, LOW_LEN) + 1);
    localparam logic [CW-1:0] HI_LAST  = CW'(TIMEOUT_CYC - 1);
    localparam logic [CW-1:0] LO_LAST  = CW'(LOW_LEN - 1);
    localparam logic [CW-1:0] MIN_LAST = CW'(MIN_LOW_CYC - 1);

    typedef struct packed {
        logic          low;
        logic          pend;
        logic          kprev;
        logic [CW-1:0] cnt;
    } core_t;

    core_t st_d, st_q;
    logic  k_rise, k_fall, k_ev, rel_req, min_ok;

    always_comb begin
        st_d       = st_q;
        st_d.kprev = kick_f;
        k_rise     = kick_f & ~st_q.kprev;
        k_fall     = ~kick_f & st_q.kprev;
        k_ev       = (MODE == WD_RISE_EARLY) ? k_rise : (k_rise | k_fall);
        min_ok     = (st_q.cnt >= MIN_LAST);
        rel_req    = st_q.pend | dis_f | ((MODE == WD_RISE_EARLY) & k_ev);

        if (!st_q.low) begin
            st_d.pend = 1'b0;
            if (dis_f || k_ev) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == HI_LAST) begin
                st_d.low = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            if ((st_q.cnt == LO_LAST) || (rel_req && min_ok)) begin
                st_d.low  = 1'b0;
                st_d.pend = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.pend = rel_req;
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wdo_n = ~st_q.low;
endmodule

// File: rtl/wdog_sup.sv
module wdog_sup
    import wdog_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 200,
    parameter int unsigned ALARM_CYC   = 120,
    parameter int unsigned MIN_LOW_CYC = 10,
    parameter int unsigned FILT_CYC    = 4,
    parameter wdog_mode_e  MODE        = WD_RISE_EARLY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic dis_i,
    output logic wdo_n_o
);
    localparam int unsigned NIN = 2;

    logic [NIN-1:0] raw_in, syn_in, flt_in;
    logic           kick_flt, dis_flt;

    assign raw_in = {dis_i, kick_i};

    for (genvar g = 0; g < NIN; g++) begin : g_in
        wdog_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .dout (syn_in[g])
        );
        wdog_filt #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (syn_in[g]),
            .dout (flt_in[g])
        );
    end

    assign kick_flt = flt_in[0];
    assign dis_flt  = flt_in[1];

    wdog_core #(
        .TIMEOUT_CYC(TIMEOUT_CYC),
        .ALARM_CYC  (ALARM_CYC),
        .MIN_LOW_CYC(MIN_LOW_CYC),
        .MODE       (MODE)
    ) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .kick_f(kick_flt),
        .dis_f (dis_flt),
        .wdo_n (wdo_n_o)
    );
endmodule

// File: rtl/wdog_sup_chk.sv
module wdog_sup_chk
    import wdog_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 200,
    parameter int unsigned ALARM_CYC   = 120,
    parameter int unsigned MIN_LOW_CYC = 10,
    parameter wdog_mode_e  MODE        = WD_RISE_EARLY
) (
    input logic clk,
    input logic rst_n,
    input logic wdo_n,
    input logic dis_f
);
    int unsigned hi_len, lo_len;
    logic        dis_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len   <= 0;
            lo_len   <= 0;
            dis_seen <= 1'b0;
        end else begin
            hi_len   <= wdo_n ? hi_len + 1 : 0;
            lo_len   <= wdo_n ? 0 : lo_len + 1;
            dis_seen <= wdo_n ? 1'b0 : (dis_seen | dis_f);
        end
    end

    // R1 / R2: a high phase never ends before a full timeout
    a_r1_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdo_n) |-> hi_len >= TIMEOUT_CYC);

    // R5 / R9: alarm never shorter than the minimum width
    a_r5_min_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdo_n) |-> lo_len >= MIN_LOW_CYC);

    // R4: rising-edge policy alarm bounded by one timeout
    a_r4_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == WD_RISE_EARLY) && $rose(wdo_n) |-> lo_len <= TIMEOUT_CYC);

    // R7: dual-edge policy alarm has fixed length unless disable intervened
    a_r7_fixed_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == WD_DUAL_FIXED) && $rose(wdo_n) && !dis_seen |-> lo_len == ALARM_CYC);

    // R8: disable keeps a high output high
    a_r8_disable_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        dis_f && wdo_n |=> wdo_n);
endmodule

bind wdog_sup wdog_sup_chk #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .ALARM_CYC  (ALARM_CYC),
    .MIN_LOW_CYC(MIN_LOW_CYC),
    .MODE       (MODE)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .wdo_n(wdo_n_o),
    .dis_f(dis_flt)
);

// File: tb/tb_wdog_sup.sv
`timescale 1ns/1ps
module tb_wdog_sup;
    import wdog_pkg::*;

    localparam int T    = 200;
    localparam int AL   = 120;
    localparam int MINW = 10;
    localparam int FILT = 4;
    localparam int KL   = FILT + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ka = 1'b0, da = 1'b0, kb = 1'b0, db = 1'b0;
    logic wa, wb;
    int   cyc;
    int   total = 0, bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    wdog_sup #(.TIMEOUT_CYC(T), .ALARM_CYC(AL), .MIN_LOW_CYC(MINW),
               .FILT_CYC(FILT), .MODE(WD_RISE_EARLY)) dut (
        .clk(clk), .rst_n(rst_n), .kick_i(ka), .dis_i(da), .wdo_n_o(wa));

    wdog_sup #(.TIMEOUT_CYC(T), .ALARM_CYC(AL), .MIN_LOW_CYC(MINW),
               .FILT_CYC(FILT), .MODE(WD_DUAL_FIXED)) dut_dual (
        .clk(clk), .rst_n(rst_n), .kick_i(kb), .dis_i(db), .wdo_n_o(wb));

    // edge at which the output falls after a kick presented before edge a+1
    function automatic int fall_after_kick(input int a);
        return a + KL + T;
    endfunction

    // edge at which the output falls after disable drops before edge b+1
    function automatic int fall_after_dis(input int b);
        return b + FILT + 2 + T;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%0b expected=%0b", req, cyc, act, exp);
        end
    endtask

    task automatic at(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ka = 0; da = 0; kb = 0; db = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    total++; bad++;
                    $display("FAIL watchdog expired cyc=%0d", cyc);
                    $display("  test done: total=%0d bad=%0d", total, bad);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        int last;
        void'($urandom(32'd5150));

        // ---------------- rising-edge policy ----------------
        do_reset();
        chk("R1 reset high", wa, 1'b1);
        chk("R1 reset high dual", wb, 1'b1);
        at(T - 1);   chk("R1", wa, 1'b1);
        at(T);       chk("R1", wa, 1'b0);
        at(2*T - 1); chk("R4", wa, 1'b0);
        at(2*T);     chk("R4", wa, 1'b1);
        at(3*T - 1); chk("R4", wa, 1'b1);
        at(3*T);     chk("R4", wa, 1'b0);
        // early kick: release held until minimum width
        at(602); ka = 1'b1;
        at(609); chk("R5 min width", wa, 1'b0);
        at(610); chk("R5 release", wa, 1'b1);
        at(700); ka = 1'b0;                          // falling edge ignored
        at(809); chk("R3", wa, 1'b1);
        at(810); chk("R3", wa, 1'b0);
        at(850); ka = 1'b1;                          // late kick in alarm
        at(856); chk("R5 late", wa, 1'b0);
        at(857); chk("R5 late", wa, 1'b1);
        at(900); ka = 1'b0;
        at(950); ka = 1'b1;
        at(1057); chk("R2 cleared", wa, 1'b1);
        at(fall_after_kick(950) - 1); chk("R2", wa, 1'b1);
        at(fall_after_kick(950));     chk("R2", wa, 1'b0);
        // disable during alarm
        at(1157); da = 1'b1;
        at(1166); chk("R9", wa, 1'b0);
        at(1167); chk("R9", wa, 1'b1);
        at(1500); chk("R8 held", wa, 1'b1);
        at(1600); da = 1'b0;
        at(fall_after_dis(1600) - 1); chk("R8", wa, 1'b1);
        at(fall_after_dis(1600));     chk("R8", wa, 1'b0);
        at(2010); ka = 1'b0;                         // falling edge while high
        at(2050); ka = 1'b1;                         // 3-cycle glitch
        at(2053); ka = 1'b0;
        at(2205); chk("R10 glitch", wa, 1'b1);
        at(2206); chk("R10 glitch", wa, 1'b0);
        at(2450); ka = 1'b1;                         // 4-cycle pulse accepted
        at(2454); ka = 1'b0;
        at(2606); chk("R10 accept", wa, 1'b1);
        at(fall_after_kick(2450) - 1); chk("R10", wa, 1'b1);
        at(fall_after_kick(2450));     chk("R10", wa, 1'b0);
        at(3050); ka = 1'b1;                         // kick lands on expiry edge
        at(3057); chk("R11", wa, 1'b1);
        at(3058); chk("R11", wa, 1'b1);
        at(3256); chk("R11", wa, 1'b1);
        at(3257); chk("R11", wa, 1'b0);

        // ---------------- dual-edge policy ----------------
        do_reset();
        at(T - 1);    chk("R7", wb, 1'b1);
        at(T);        chk("R7", wb, 1'b0);
        at(T + AL - 1); chk("R7", wb, 1'b0);
        at(T + AL);     chk("R7", wb, 1'b1);
        at(2*T + AL - 1); chk("R7", wb, 1'b1);
        at(2*T + AL);     chk("R7", wb, 1'b0);
        at(530); kb = 1'b1;                          // ignored during alarm
        at(639); chk("R7 fixed", wb, 1'b0);
        at(640); chk("R7 fixed", wb, 1'b1);
        at(700); kb = 1'b0;                          // falling edge accepted
        at(840); chk("R6 fall", wb, 1'b1);
        at(fall_after_kick(700) - 1); chk("R6", wb, 1'b1);
        at(fall_after_kick(700));     chk("R6", wb, 1'b0);
        at(1100); kb = 1'b1;
        at(1227); chk("R6 rise", wb, 1'b1);
        at(fall_after_kick(1100) - 1); chk("R6", wb, 1'b1);
        at(fall_after_kick(1100));     chk("R6", wb, 1'b0);
        at(1310); db = 1'b1;
        at(1316); chk("R9 dual", wb, 1'b0);
        at(1317); chk("R9 dual", wb, 1'b1);
        at(1400); db = 1'b0;
        at(fall_after_dis(1400) - 1); chk("R8 dual", wb, 1'b1);
        at(fall_after_dis(1400));     chk("R8 dual", wb, 1'b0);

        // random toggling with disable glitches
        at(1730);
        kb = ~kb;
        last = cyc;
        for (int i = 0; i < 40; i++) begin
            int gap, w;
            gap = 10 + int'($urandom % 81);
            w   = 1 + int'($urandom % 3);
            for (int c = 0; c < gap; c++) begin
                @(negedge clk);
                chk("R6 random", wb, 1'b1);
                if (c == 4)     db = 1'b1;
                if (c == 4 + w) db = 1'b0;
            end
            kb = ~kb;
            last = cyc;
        end
        at(fall_after_kick(last) - 1); chk("R2 random", wb, 1'b1);
        at(fall_after_kick(last));     chk("R2 random", wb, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule